// File: doc/BRIEF.md
# Configurable Bit-Serial CRC Engine

This block computes a cyclic redundancy check one bit per clock. It both generates and checks. The state is an n-bit remainder register. Each accepted message bit is combined with the coefficient that leaves the register, at the moment that coefficient is tested. Because of this, the engine needs neither an extra register bit nor n trailing zero bits to flush the division. Parameters fix the generator polynomial, the register form and the initial value, and they set whether the output is complemented. The polynomial is written with its leading term dropped, and the defaults select x^16+x^12+x^5+1.

A frame opens with a start pulse. The pulse loads the initial value, and a data bit may be accepted in the same cycle. The caller presents bits with a valid strobe and flags the final bit with a last marker. To generate a CRC, the caller reads the CRC output after the last message bit. To check a frame, the caller sends the message followed by its CRC in transmission order and marks the final CRC bit as last. One cycle later a flag reports whether the remainder equals the expected constant. That constant is zero without output complement, and a fixed non-zero value with it.

Top module: `crc_serial_engine`

## Requirements
- R1: While `rst_ni` is low and after its release, `crc_o` equals the initial register value XOR the output mask, and `check_ok_o` is 0. The initial register value is `PRESET` when `PRESET_EN`=1 and 0 otherwise. The output mask is all ones when `INVERT_OUT`=1 and 0 otherwise.
- R2: A cycle with `start_i`=1 loads the initial register value. If `valid_i` is also 1 in that cycle, the data bit is processed starting from that initial value.
- R3: With `LSB_FIRST`=0, an accepted bit d updates the register as follows. Let f = reg[n-1] XOR d. The register shifts left by one with 0 entering bit 0. When f=1 it is then XORed with `POLY` (default 0x1021).
- R4: With `LSB_FIRST`=1, an accepted bit d updates the register as follows. Let f = reg[0] XOR d. The register shifts right by one with 0 entering bit n-1. When f=1 it is then XORed with the bit reversal of `POLY` (0x8408 for the default).
- R5: In a cycle with `valid_i`=0 and `start_i`=0, the register keeps its value, and `data_i` and `last_i` have no effect.
- R6: `crc_o` equals the register XOR the output mask and reflects every bit accepted up to the previous clock edge.
- R7: The frame is the message followed by its correct CRC. In msbit form the CRC is sent as `crc_o` bit n-1 first. In lsbit form it is sent as `crc_o` bit 0 first. Marking the final CRC bit with `last_i`=1 gives `check_ok_o`=1 in the next cycle only. `check_ok_o` is 0 in every cycle that does not follow an accepted last bit.
- R8: If any single bit of the appended CRC is flipped, `check_ok_o` is 0 in the cycle after the last bit.
- R9: A non-zero `PRESET` other than all ones gives correct generation and a correct check outcome, provided generator and checker use the same value.

Top-level parameters: `WIDTH` sets the register width n, `POLY` sets the generator polynomial without its leading term, and `LSB_FIRST` selects the register form. `PRESET_EN`, `PRESET` and `INVERT_OUT` set the initial value and the output complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load the initial value; a bit may be accepted in the same cycle |
| valid_i | input | 1 | `data_i` carries a message bit this cycle |
| data_i | input | 1 | Serial message bit |
| last_i | input | 1 | The accepted bit is the final bit of the frame |
| crc_o | output | WIDTH | Register value after the output mask |
| check_ok_o | output | 1 | One-cycle pulse: remainder after the frame matched the expected constant |

## Verification
The assertions assume that `last_i` matters only together with `valid_i`. They also assume that a check result is wanted only for frames that begin with a start pulse after reset. The stimulus therefore always opens a frame with `start_i` and toggles `last_i` freely during idle cycles. The stimulus inserts idle gaps with random data between accepted bits, and it leaves at least one idle cycle between frames. This keeps each flag pulse tied to exactly one accepted last bit. Lengths run from 1 to 64 bytes. Both register forms are used, with every combination of initial value and output complement, plus one unusual initial value.

// File: rtl/crc_serial_pkg.sv
package crc_serial_pkg;

  localparam int unsigned CRC_MAX_W = 64;
  typedef logic [CRC_MAX_W-1:0] crc_word_t;

  function automatic crc_word_t width_mask(int unsigned w);
    crc_word_t m;
    m = '0;
    for (int unsigned i = 0; i < CRC_MAX_W; i++) if (i < w) m[i] = 1'b1;
    return m;
  endfunction

  function automatic crc_word_t bit_rev(crc_word_t v, int unsigned w);
    crc_word_t r;
    r = '0;
    for (int unsigned i = 0; i < CRC_MAX_W; i++) if (i < w) r[w-1-i] = v[i];
    return r;
  endfunction

  // Raw remainder left by a correct frame when the appended CRC was complemented:
  // equivalent to feeding w ones into a zeroed msbit-form register.
  function automatic crc_word_t ones_residue(crc_word_t poly, int unsigned w);
    crc_word_t s;
    logic      fb;
    s = '0;
    for (int unsigned i = 0; i < CRC_MAX_W; i++) begin
      if (i < w) begin
        fb = s[w-1] ^ 1'b1;
        s  = (s << 1) & width_mask(w);
        if (fb) s = s ^ (poly & width_mask(w));
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
  parameter int unsigned WIDTH     = 16,
  parameter bit          LSB_FIRST = 1'b0,
  parameter logic [WIDTH-1:0] TAP  = 16'h1021
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] state_o
);

  logic fb;

  generate
    if (LSB_FIRST) begin : g_lsb
      always_comb begin
        fb      = state_i[0] ^ bit_i;
        state_o = (state_i >> 1) ^ (fb ? TAP : '0);
      end
    end else begin : g_msb
      always_comb begin
        fb      = state_i[WIDTH-1] ^ bit_i;
        state_o = (state_i << 1) ^ (fb ? TAP : '0);
      end
    end
  endgenerate

endmodule

// File: rtl/crc_residue_flag.sv
module crc_residue_flag #(
  parameter int unsigned      WIDTH   = 16,
  parameter logic [WIDTH-1:0] RESIDUE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eom_i,
  input  logic [WIDTH-1:0] state_i,
  output logic             ok_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_o <= 1'b0;
    else         ok_o <= eom_i && (state_i == RESIDUE);
  end

  p_flag_after_eom_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> $past(eom_i));

  p_flag_low_on_mismatch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eom_i && state_i != RESIDUE) |=> !ok_o);

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_serial_pkg::*;
#(
  parameter int unsigned      WIDTH      = 16,
  parameter logic [WIDTH-1:0] POLY       = 16'h1021,
  parameter bit               LSB_FIRST  = 1'b0,
  parameter bit               PRESET_EN  = 1'b1,
  parameter logic [WIDTH-1:0] PRESET     = '1,
  parameter bit               INVERT_OUT = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  logic             data_i,
  input  logic             last_i,
  output logic [WIDTH-1:0] crc_o,
  output logic             check_ok_o
);

  localparam crc_word_t        TAP_W     = LSB_FIRST ? bit_rev(crc_word_t'(POLY), WIDTH)
                                                     : crc_word_t'(POLY);
  localparam logic [WIDTH-1:0] TAP       = TAP_W[WIDTH-1:0];
  localparam logic [WIDTH-1:0] START_VAL = PRESET_EN ? PRESET : '0;
  localparam logic [WIDTH-1:0] OUT_MASK  = INVERT_OUT ? '1 : '0;
  localparam crc_word_t        RES_MSB   = ones_residue(crc_word_t'(POLY), WIDTH);
  localparam crc_word_t        RES_W     = LSB_FIRST ? bit_rev(RES_MSB, WIDTH) : RES_MSB;
  localparam logic [WIDTH-1:0] RESIDUE   = INVERT_OUT ? RES_W[WIDTH-1:0] : '0;

  logic [WIDTH-1:0] raw_q, raw_d, base, stepped;

  assign base = start_i ? START_VAL : raw_q;

  crc_bit_step #(
    .WIDTH    (WIDTH),
    .LSB_FIRST(LSB_FIRST),
    .TAP      (TAP)
  ) u_step (
    .state_i(base),
    .bit_i  (data_i),
    .state_o(stepped)
  );

  assign raw_d = valid_i ? stepped : base;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= START_VAL;
    else         raw_q <= raw_d;
  end

  assign crc_o = raw_q ^ OUT_MASK;

  crc_residue_flag #(
    .WIDTH  (WIDTH),
    .RESIDUE(RESIDUE)
  ) u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .eom_i  (valid_i && last_i),
    .state_i(stepped),
    .ok_o   (check_ok_o)
  );

  p_hold_when_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !valid_i) |=> $stable(crc_o));

  p_start_loads_preset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_i) |=> (crc_o == (START_VAL ^ OUT_MASK)));

endmodule

// File: tb/tb_crc_harness.sv
module tb_crc_harness #(
  parameter bit          LSB   = 1'b0,
  parameter bit          PRE   = 1'b1,
  parameter logic [15:0] PVAL  = 16'hFFFF,
  parameter bit          INV   = 1'b1,
  parameter bit          ODDP  = 1'b0,
  parameter int          SEED  = 1
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   fails,
  output logic done
);

  logic        start, valid, data, last;
  logic [15:0] crc;
  logic        ok;

  crc_serial_engine #(
    .WIDTH(16), .POLY(16'h1021), .LSB_FIRST(LSB),
    .PRESET_EN(PRE), .PRESET(PVAL), .INVERT_OUT(INV)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid),
    .data_i(data), .last_i(last), .crc_o(crc), .check_ok_o(ok)
  );

  localparam logic [15:0] MASK = INV ? 16'hFFFF : 16'h0000;
  localparam logic [15:0] P0   = PRE ? PVAL : 16'h0000;

  bit          stream[$];
  logic [15:0] exp_crc;
  logic        exp_ok;
  logic        frame_good;
  string       pend_tag;

  // Long division with an n+1-bit remainder and explicit zero padding.
  function automatic logic [15:0] model_raw();
    logic [16:0] r;
    logic [16:0] p;
    logic [15:0] s, v;
    r = '0;
    foreach (stream[i]) begin
      r = {r[15:0], stream[i]};
      if (r[16]) r = r ^ 17'h11021;
    end
    for (int k = 0; k < 16; k++) begin
      r = {r[15:0], 1'b0};
      if (r[16]) r = r ^ 17'h11021;
    end
    p = {1'b0, P0};
    foreach (stream[i]) begin
      p = {p[15:0], 1'b0};
      if (p[16]) p = p ^ 17'h11021;
    end
    s = r[15:0] ^ p[15:0];
    if (LSB) begin
      for (int k = 0; k < 16; k++) v[k] = s[15-k];
      return v;
    end
    return s;
  endfunction

  task automatic compare();
    checks++;
    if (crc !== exp_crc) begin
      fails++;
      $display("FAIL %s crc_o lsb=%0d pre=%0d inv=%0d actual=%h expected=%h",
               pend_tag, LSB, PRE, INV, crc, exp_crc);
    end
    checks++;
    if (ok !== exp_ok) begin
      fails++;
      $display("FAIL %s check_ok_o lsb=%0d pre=%0d inv=%0d actual=%0b expected=%0b",
               (exp_ok ? "R7" : (frame_good ? pend_tag : "R8")), LSB, PRE, INV, ok, exp_ok);
    end
  endtask

  task automatic step(bit st, bit v, bit b, bit l, string tag);
    @(negedge clk);
    compare();
    start = st; valid = v; data = b; last = l;
    if (st) stream.delete();
    if (v) stream.push_back(b);
    exp_crc  = model_raw() ^ MASK;
    exp_ok   = v && l && frame_good;
    pend_tag = tag;
  endtask

  initial begin
    string       btag;
    logic [15:0] sent;
    int          nbytes;
    checks = 0; fails = 0; done = 1'b0;
    start = 0; valid = 0; data = 0; last = 0;
    frame_good = 1'b1;
    void'($urandom(SEED));
    exp_crc  = P0 ^ MASK;
    exp_ok   = 1'b0;
    pend_tag = "R1";
    repeat (2) @(negedge clk);
    compare();
    wait (rst_n);
    btag = ODDP ? "R9" : (LSB ? "R4" : "R3");
    for (int m = 0; m < 6; m++) begin
      nbytes = (m == 0) ? 1 : (m == 1) ? 64 : 1 + int'($urandom % 64);
      frame_good = (m != 3);
      step(0, 0, 1'($urandom), 1'($urandom), "R5");
      if (m % 2 == 0) step(1, 0, 1'($urandom), 0, "R2");
      for (int i = 0; i < nbytes * 8; i++) begin
        if ($urandom % 4 == 0) step(0, 0, 1'($urandom), 1'($urandom), "R5");
        step((m % 2 == 1) && (i == 0), 1, 1'($urandom), 0,
             (i == nbytes * 8 - 1) ? "R6" : ((m % 2 == 1 && i == 0) ? "R2" : btag));
      end
      sent = exp_crc;
      if (m == 3) sent[5] = ~sent[5];
      for (int k = 0; k < 16; k++) begin
        if ($urandom % 5 == 0) step(0, 0, 1'($urandom), 1'($urandom), "R5");
        step(0, 1, LSB ? sent[k] : sent[15-k], k == 15,
             (k == 15) ? ((m == 3) ? "R8" : "R7") : btag);
      end
      step(0, 0, 0, 0, "R7");
      step(0, 0, 0, 1, "R5");
    end
    @(negedge clk);
    compare();
    done = 1'b1;
  end

endmodule

// File: tb/tb_crc_serial_engine.sv
module tb_crc_serial_engine;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  localparam int NCFG = 9;
  int   chk [NCFG];
  int   bad [NCFG];
  logic [NCFG-1:0] fin;

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    localparam bit          L  = (i < 8) ? ((i % 2) != 0) : 1'b0;
    localparam bit          PE = (i < 8) ? (((i / 2) % 2) != 0) : 1'b1;
    localparam bit          IV = (i < 8) ? (((i / 4) % 2) != 0) : 1'b1;
    localparam logic [15:0] PV = (i < 8) ? 16'hFFFF : 16'hB5A3;
    tb_crc_harness #(
      .LSB(L), .PRE(PE), .PVAL(PV), .INV(IV), .ODDP(i == 8), .SEED(17 + 31 * i)
    ) u_h (
      .clk(clk), .rst_n(rst_n), .checks(chk[i]), .fails(bad[i]), .done(fin[i])
    );
  end

  initial begin
    int cyc;
    int total_c;
    int total_f;
    cyc = 0;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    while (fin !== '1 && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    total_c = 0;
    total_f = 0;
    for (int i = 0; i < NCFG; i++) begin
      total_c += chk[i];
      total_f += bad[i];
    end
    if (fin !== '1) begin
      total_c++;
      total_f++;
      $display("FAIL watchdog: actual=hung expected=all configurations done");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", total_c, total_f);
    $finish;
  end

endmodule